// File: doc/BRIEF.md
# Programmable Bit-Reduction Stage

This block takes a wide signed accumulator or product word and turns it into a narrower signed fixed-point word, for example a Q1.17 or Q2.16 sample. Each valid input goes through three steps. First it is shifted right by a base amount plus a small offset chosen by software. Next it is either truncated or rounded half up. Last it is saturated to the output range.

The offset takes one of four values. This lets software move the output range by up to three bits while the datapath stays fixed. Every output sample carries a bit that marks it as clamped. A sticky overflow flag collects those marks until software clears it. Together they let software tune the shift setting from observed overflow.

Top module: `bitred_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `dataOut`, `validOut`, `satOut` and `stickyOvf` are all zero.
- R2: `validOut` is high exactly one clock after `validIn` was high. In a cycle where `validIn` is low, `dataOut` and `satOut` keep their previous values.
- R3: With `roundMode` = 0, the result is the input, read as two's complement, divided by 2^(DROP + `shiftSel`) and rounded toward negative infinity. `shiftSel` is a 2-bit unsigned value from 0 to 3.
- R4: With `roundMode` = 1, the value 2^(DROP + `shiftSel` - 1) is added to the input before the floor division of R3. This rounds half up.
- R5: If the result lies outside [-2^(OUT_W-1), 2^(OUT_W-1)-1], `dataOut` is set to the nearer bound and `satOut` is 1. Otherwise `dataOut` is the result and `satOut` is 0.
- R6: If the rounding increment pushes a value past the most positive code, the output is clamped to the most positive code and `satOut` is set, even though the truncated value would have fit.
- R7: `stickyOvf` goes high one clock after a valid sample that saturates. It then stays high until it is cleared.
- R8: When `clearFlag` is high, `stickyOvf` is zero on the next clock. This holds even if a saturating sample arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | IN_W | Wide signed input word |
| validIn | input | 1 | Input sample strobe |
| shiftSel | input | 2 | Extra right shift, 0 to 3 |
| roundMode | input | 1 | 0 selects truncation, 1 selects round half up |
| clearFlag | input | 1 | Clears the sticky overflow flag |
| dataOut | output | OUT_W | Narrow signed output word |
| validOut | output | 1 | Output sample strobe |
| satOut | output | 1 | The current output sample was clamped |
| stickyOvf | output | 1 | Saturation seen since the last clear |

## Verification
The assertions assume four things about the inputs. `dataIn` is a plain two's-complement value. `shiftSel` and `roundMode` are valid in every cycle in which `validIn` is high. DROP + 3 is smaller than IN_W, so the rounding increment always fits in the widened sum. The bench uses a 10-bit input, a 6-bit output and DROP = 2, which keeps every sample inside these assumptions. It sweeps every input code under every shift and rounding setting. It changes inputs only on the falling clock edge, and it also drives idle cycles with random-looking data to confirm that the output is held.

// File: rtl/bitred_pkg.sv
package bitred_pkg;
  localparam int SHIFT_SEL_W = 2;

  typedef struct packed {
    logic capture;
    logic clearSticky;
  } redStrobe_t;
endpackage

// File: rtl/bitred_ctrl.sv
module bitred_ctrl
  import bitred_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       validIn,
  input  logic       clearFlag,
  input  logic       satNow,
  output redStrobe_t strobe,
  output logic       validOut,
  output logic       stickyOvf
);

  always_comb begin
    strobe.capture     = validIn;
    strobe.clearSticky = clearFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validOut  <= 1'b0;
      stickyOvf <= 1'b0;
    end else begin
      validOut <= strobe.capture;
      if (strobe.clearSticky)
        stickyOvf <= 1'b0;
      else if (strobe.capture && satNow)
        stickyOvf <= 1'b1;
    end
  end

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearFlag |=> !stickyOvf);

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stickyOvf && !clearFlag) |=> stickyOvf);

endmodule

// File: rtl/bitred_datapath.sv
module bitred_datapath
  import bitred_pkg::*;
#(
  parameter int IN_W  = 36,
  parameter int OUT_W = 18,
  parameter int DROP  = 17,
  parameter int SEL_W = SHIFT_SEL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  redStrobe_t       strobe,
  input  logic [IN_W-1:0]  dataIn,
  input  logic [SEL_W-1:0] shiftSel,
  input  logic             roundMode,
  output logic             satNow,
  output logic [OUT_W-1:0] dataOut,
  output logic             satOut
);

  localparam int NSH   = 1 << SEL_W;
  localparam int EXT_W = IN_W + 1;
  localparam int TOP_W = EXT_W - OUT_W + 1;
  localparam logic [OUT_W-1:0] MAX_CODE = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

  logic [OUT_W-1:0] candVal [NSH];
  logic [NSH-1:0]   candSat;
  logic signed [EXT_W-1:0] extIn;

  assign extIn = {dataIn[IN_W-1], dataIn};

  for (genvar k = 0; k < NSH; k++) begin : g_shift
    localparam int SH = DROP + k;
    logic signed [EXT_W-1:0] addend;
    logic signed [EXT_W-1:0] sum;
    logic signed [EXT_W-1:0] shifted;
    logic [TOP_W-1:0]        upper;
    logic                    fits;

    if (SH > 0) begin : g_rnd
      assign addend = roundMode ? ({{(EXT_W-1){1'b0}}, 1'b1} << (SH - 1)) : '0;
    end else begin : g_nornd
      assign addend = '0;
    end

    assign sum     = extIn + addend;
    assign shifted = sum >>> SH;
    assign upper   = shifted[EXT_W-1:OUT_W-1];
    assign fits    = (&upper) | ~(|upper);
    assign candSat[k] = ~fits;
    assign candVal[k] = fits ? shifted[OUT_W-1:0]
                             : (sum[EXT_W-1] ? MIN_CODE : MAX_CODE);
  end

  logic [OUT_W-1:0] selVal;
  always_comb begin
    selVal = candVal[shiftSel];
    satNow = candSat[shiftSel];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut <= '0;
      satOut  <= 1'b0;
    end else if (strobe.capture) begin
      dataOut <= selVal;
      satOut  <= satNow;
    end
  end

  // R5
  clamp_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    satOut |-> (dataOut == MAX_CODE || dataOut == MIN_CODE));

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(dataOut) && $stable(satOut)));

endmodule

// File: rtl/bitred_top.sv
module bitred_top
  import bitred_pkg::*;
#(
  parameter int IN_W  = 36,
  parameter int OUT_W = 18,
  parameter int DROP  = 17
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [IN_W-1:0]        dataIn,
  input  logic                   validIn,
  input  logic [SHIFT_SEL_W-1:0] shiftSel,
  input  logic                   roundMode,
  input  logic                   clearFlag,
  output logic [OUT_W-1:0]       dataOut,
  output logic                   validOut,
  output logic                   satOut,
  output logic                   stickyOvf
);

  redStrobe_t strobe;
  logic       satNow;

  bitred_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .validIn   (validIn),
    .clearFlag (clearFlag),
    .satNow    (satNow),
    .strobe    (strobe),
    .validOut  (validOut),
    .stickyOvf (stickyOvf)
  );

  bitred_datapath #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W),
    .DROP  (DROP),
    .SEL_W (SHIFT_SEL_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dataIn    (dataIn),
    .shiftSel  (shiftSel),
    .roundMode (roundMode),
    .satNow    (satNow),
    .dataOut   (dataOut),
    .satOut    (satOut)
  );

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);

endmodule

// File: tb/bitred_top_tb_top.sv
`timescale 1ns/1ps
module bitred_top_tb_top;
  localparam int IN_W  = 10;
  localparam int OUT_W = 6;
  localparam int DROP  = 2;
  localparam int MAXV  = (1 << (OUT_W - 1)) - 1;
  localparam int MINV  = -(1 << (OUT_W - 1));

  logic             clk = 1'b0;
  logic             rstN;
  logic [IN_W-1:0]  dataIn;
  logic             validIn;
  logic [1:0]       shiftSel;
  logic             roundMode;
  logic             clearFlag;
  logic [OUT_W-1:0] dataOut;
  logic             validOut;
  logic             satOut;
  logic             stickyOvf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit expSticky = 1'b0;
  int lastVal = 0;
  bit lastSat = 1'b0;

  always #2.5 clk = ~clk;

  bitred_top #(.IN_W(IN_W), .OUT_W(OUT_W), .DROP(DROP)) dut_i (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .validIn(validIn),
    .shiftSel(shiftSel), .roundMode(roundMode), .clearFlag(clearFlag),
    .dataOut(dataOut), .validOut(validOut), .satOut(satOut),
    .stickyOvf(stickyOvf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Drive one valid sample and check the registered result one clock later.
  task automatic sample(input int v, input int sel, input int mode, input bit clr);
    int sh, x, y, yt, expV;
    bit sat, carrySat;
    string tag;
    dataIn    = IN_W'(v);
    shiftSel  = 2'(sel);
    roundMode = mode[0];
    clearFlag = clr;
    validIn   = 1'b1;
    sh = DROP + sel;
    x  = v;
    yt = v >>> sh;
    if (mode != 0 && sh > 0) x = x + (1 << (sh - 1));
    y = x >>> sh;
    sat = (y > MAXV) || (y < MINV);
    carrySat = sat && (yt <= MAXV) && (yt >= MINV);
    expV = (y > MAXV) ? MAXV : ((y < MINV) ? MINV : y);
    tag = carrySat ? "R6" : (sat ? "R5" : (mode != 0 ? "R4" : "R3"));
    expSticky = clr ? 1'b0 : (expSticky | sat);
    @(negedge clk);
    chk(validOut == 1'b1, "R2 validOut", int'(validOut), 1);
    chk(int'($signed(dataOut)) == expV, tag, int'($signed(dataOut)), expV);
    chk(satOut == sat, carrySat ? "R6 satOut" : "R5 satOut", int'(satOut), int'(sat));
    chk(stickyOvf == expSticky, clr ? "R8 sticky" : "R7 sticky",
        int'(stickyOvf), int'(expSticky));
    lastVal = expV;
    lastSat = sat;
  endtask

  task automatic idle(input int v, input bit clr);
    dataIn    = IN_W'(v);
    shiftSel  = 2'(v);
    roundMode = v[2];
    clearFlag = clr;
    validIn   = 1'b0;
    if (clr) expSticky = 1'b0;
    @(negedge clk);
    chk(validOut == 1'b0, "R2 idle validOut", int'(validOut), 0);
    chk(int'($signed(dataOut)) == lastVal, "R2 hold dataOut", int'($signed(dataOut)), lastVal);
    chk(satOut == lastSat, "R2 hold satOut", int'(satOut), int'(lastSat));
    chk(stickyOvf == expSticky, clr ? "R8 idle clear" : "R7 idle sticky",
        int'(stickyOvf), int'(expSticky));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; validIn = 1'b0; dataIn = '0; shiftSel = '0;
    roundMode = 1'b0; clearFlag = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs are zero while reset is held
    chk(dataOut == '0 && validOut == 1'b0 && satOut == 1'b0 && stickyOvf == 1'b0,
        "R1 in reset", int'({dataOut, validOut, satOut, stickyOvf}), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: outputs are still zero on the first cycle after reset
    chk(dataOut == '0 && validOut == 1'b0 && satOut == 1'b0 && stickyOvf == 1'b0,
        "R1 after reset", int'({dataOut, validOut, satOut, stickyOvf}), 0);

    // Every input code under every shift and rounding setting (R3 R4 R5 R6 R7)
    for (int mode = 0; mode < 2; mode++) begin
      for (int sel = 0; sel < 4; sel++) begin
        idle(sel * 37 + mode, 1'b1);
        for (int v = -(1 << (IN_W - 1)); v < (1 << (IN_W - 1)); v++) begin
          sample(v, sel, mode, 1'b0);
          if ((v & 63) == 5) idle(v * 13 + 7, 1'b0);
        end
      end
    end

    // R8: clear takes priority over a saturating sample in the same cycle
    sample(511, 0, 0, 1'b0);
    sample(-512, 0, 1, 1'b1);
    idle(3, 1'b0);
    // R6: a rounding carry past the top code sets the sticky flag
    sample(126, 0, 1, 1'b0);
    idle(9, 1'b0);
    idle(1, 1'b1);
    sample(0, 3, 1, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule